// File: doc/BRIEF.md
# Duplex-Aware FIFO DMA Request Logic

This block sits between a MAC's transmit and receive FIFOs and the DMA engine that fills and empties them. It decides, each cycle, whether to raise a transmit DMA request (room in the transmit FIFO) and a receive DMA request (data waiting in the receive FIFO). Each direction compares the FIFO state with a 2-bit watermark select, and the duplex mode controls two protection gates.

In half duplex a collision can force a retransmission. The block therefore marks the head of each outgoing frame as retained until 64 bytes (512 bit times) have left the FIFO. Bytes already sent from that head still occupy storage, so they reduce the free space seen by the transmit request. On the receive side, half duplex blocks watermark-driven receive DMA while a frame has fewer than 64 bytes, and it drops short frames. In full duplex, or when the runt-accept control is set, the receive gates are removed. A completed valid frame of any length then requests receive DMA at once.

The FIFO storage, the DMA engine and the serialiser are outside the block. They report to it through occupancy counts and single-cycle strobes.

Top module: `dupDmaReq`

## Requirements
- R1: While rstN is low at a clock edge, txDmaReq, rxDmaReq and txRetainHead are all 0 after that edge.
- R2: Watermark select codes 0, 1, 2 and 3 mean 16, 64, 128 and 256 bytes. With no head retained, txDmaReq is 1 in the cycle after the free space (TX_DEPTH - txLevel) is at least the transmit watermark, and 0 otherwise.
- R3: In half duplex, txStart sets txRetainHead from the next cycle. It stays set until the 64th txByteSent strobe of that frame, and it is 0 after that strobe's edge.
- R4: While txRetainHead is set, the bytes of the frame already sent count as occupied, so txDmaReq compares (TX_DEPTH - txLevel - bytesSent) with the watermark.
- R5: txAbort clears txRetainHead at the next edge, and it takes priority over a txStart in the same cycle.
- R6: In full duplex, txStart never sets txRetainHead. Entering full duplex clears a retained head, and txDmaReq ignores bytes already sent.
- R7: In full duplex or with runtAccept set, rxDmaReq is 1 in the cycle after rxLevel is at least the receive watermark.
- R8: In full duplex, an rxEof strobe with rxFrameOk=1 raises rxDmaReq in the next cycle, whatever rxFrameLen is and even below the watermark. The request stays up until rxLevel reaches 0.
- R9: In half duplex with runtAccept=0, the watermark path gives no receive request while rxByteCnt is between 1 and 63. It works again once rxByteCnt is 0 or at least 64.
- R10: rxDmaReq returns to 0 in the cycle after rxLevel is below the watermark with no completed frame pending.
- R11: An rxEof with rxFrameOk=0 never raises a request. In half duplex with runtAccept=0, a valid frame with rxFrameLen below 64 does not raise one either, while one of 64 bytes or more does.
- R12: In half duplex with runtAccept=1, receive requests follow the full-duplex rule: no 64-byte gate, and short valid frames request DMA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| fullDuplex | input | 1 | 1 selects full-duplex operation |
| runtAccept | input | 1 | In half duplex, removes the receive 64-byte gates |
| txWmSel | input | 2 | Transmit watermark select |
| rxWmSel | input | 2 | Receive watermark select |
| txLevel | input | TX_W | Bytes in the transmit FIFO not yet sent |
| rxLevel | input | RX_W | Bytes in the receive FIFO |
| txStart | input | 1 | Strobe: a frame begins transmission |
| txByteSent | input | 1 | Strobe: one byte left the transmit FIFO |
| txAbort | input | 1 | Strobe: the current transmit frame is abandoned |
| rxEof | input | 1 | Strobe: the receive frame ended |
| rxFrameOk | input | 1 | Qualifies rxEof: frame is valid |
| rxFrameLen | input | LEN_W | Length of the frame ending at rxEof |
| rxByteCnt | input | LEN_W | Bytes received so far of the frame in progress, 0 when idle |
| txDmaReq | output | 1 | Registered transmit DMA request |
| rxDmaReq | output | 1 | Registered receive DMA request |
| txRetainHead | output | 1 | Registered: keep the frame head for a retry |

## Verification
The transmit request is driven with free space exactly at each watermark and one byte short of it, which pins down each code's threshold. A frame of bytes is then sent with a level chosen one byte below the watermark. Full duplex raises the request after a few bytes, half duplex does not until the head is released, and this separates the two accounting modes. On the receive side, the watermark edge is probed per code. The half-duplex gate is tried with a partial frame below and at 64 bytes. Frame ends are tried with short valid, long valid and invalid frames, strict and with runt acceptance, which separates the end-of-frame path from the watermark path.

// File: rtl/dupDmaPkg.sv
package dupDmaPkg;

  localparam int unsigned HEAD_BYTES = 64;

  typedef struct packed {
    logic relaxed;
    logic retainOn;
    logic clrSent;
    logic incSent;
    logic rxGateOpen;
    logic rxPendNext;
  } ctlStrobe_t;

  function automatic int unsigned wmBytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd1:    return 64;
      2'd2:    return 128;
      default: return 256;
    endcase
  endfunction

endpackage

// File: rtl/dupDmaCtrl.sv
module dupDmaCtrl
  import dupDmaPkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fullDuplex,
  input  logic             runtAccept,
  input  logic             txStart,
  input  logic             txAbort,
  input  logic             txByteSent,
  input  logic             headDone,
  input  logic             rxEof,
  input  logic             rxFrameOk,
  input  logic [LEN_W-1:0] rxFrameLen,
  input  logic [LEN_W-1:0] rxByteCnt,
  input  logic             rxLevelZero,
  output ctlStrobe_t       ctl,
  output logic             retainHead
);

  typedef enum logic {HEAD_FREE, HEAD_HELD} headState_t;

  localparam logic [LEN_W-1:0] HEAD_LEN = LEN_W'(HEAD_BYTES);

  headState_t headQ, headD;
  logic       pendQ;
  logic       relaxed;
  logic       eofValid;
  logic       gateOpen;
  logic       pendNext;

  assign relaxed = fullDuplex | runtAccept;

  // Retained-head state: entered on a half-duplex start, left on abort,
  // on a change to full duplex, or at the last byte of the head.
  always_comb begin
    headD = headQ;
    unique case (headQ)
      HEAD_FREE: begin
        if (txStart && !txAbort && !fullDuplex) headD = HEAD_HELD;
      end
      HEAD_HELD: begin
        if (txAbort || fullDuplex)         headD = HEAD_FREE;
        else if (txStart)                  headD = HEAD_HELD;
        else if (txByteSent && headDone)   headD = HEAD_FREE;
      end
      default: headD = HEAD_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) headQ <= HEAD_FREE;
    else       headQ <= headD;
  end

  // Receive gating.
  assign gateOpen = relaxed || (rxByteCnt == '0) || (rxByteCnt >= HEAD_LEN);
  assign eofValid = rxEof && rxFrameOk && (relaxed || (rxFrameLen >= HEAD_LEN));
  assign pendNext = eofValid || (pendQ && !rxLevelZero);

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= pendNext;
  end

  always_comb begin
    ctl            = '0;
    ctl.relaxed    = relaxed;
    ctl.retainOn   = (headQ == HEAD_HELD);
    ctl.clrSent    = txStart;
    ctl.incSent    = (headQ == HEAD_HELD) && txByteSent && !txStart;
    ctl.rxGateOpen = gateOpen;
    ctl.rxPendNext = pendNext;
  end

  assign retainHead = (headQ == HEAD_HELD);

endmodule

// File: rtl/dupDmaDatapath.sv
module dupDmaDatapath
  import dupDmaPkg::*;
#(
  parameter int TX_DEPTH = 512,
  parameter int RX_DEPTH = 512,
  localparam int TX_W = $clog2(TX_DEPTH + 1),
  localparam int RX_W = $clog2(RX_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      ctl,
  input  logic [1:0]      txWmSel,
  input  logic [1:0]      rxWmSel,
  input  logic [TX_W-1:0] txLevel,
  input  logic [RX_W-1:0] rxLevel,
  output logic            headDone,
  output logic            rxLevelZero,
  output logic            txDmaReq,
  output logic            rxDmaReq
);

  localparam int HEAD_W = $clog2(HEAD_BYTES + 1);
  localparam int TXC_W  = TX_W + 1;
  localparam int RXC_W  = (RX_W > 9 ? RX_W : 9) + 1;

  logic [HEAD_W-1:0] sentCnt;
  logic [TXC_W-1:0]  txRoom, txHeld, txFree, txWm;
  logic [RXC_W-1:0]  rxWm;
  logic              txHit, rxHit;

  // Count of head bytes already sent while the head is retained.
  always_ff @(posedge clk) begin
    if (!rstN)            sentCnt <= '0;
    else if (ctl.clrSent) sentCnt <= '0;
    else if (ctl.incSent) sentCnt <= sentCnt + 1'b1;
  end

  assign headDone    = (sentCnt == HEAD_W'(HEAD_BYTES - 1));
  assign rxLevelZero = (rxLevel == '0);

  // Transmit free space, less the retained head bytes.
  always_comb begin
    if ({1'b0, txLevel} >= TXC_W'(TX_DEPTH)) txRoom = '0;
    else txRoom = TXC_W'(TX_DEPTH) - {1'b0, txLevel};
    txHeld = ctl.retainOn ? TXC_W'(sentCnt) : '0;
    txFree = (txHeld > txRoom) ? '0 : (txRoom - txHeld);
    txWm   = TXC_W'(wmBytes(txWmSel));
    rxWm   = RXC_W'(wmBytes(rxWmSel));
  end

  assign txHit = (txFree >= txWm);
  assign rxHit = (RXC_W'(rxLevel) >= rxWm) && ctl.rxGateOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txDmaReq <= 1'b0;
      rxDmaReq <= 1'b0;
    end else begin
      txDmaReq <= txHit;
      rxDmaReq <= rxHit || ctl.rxPendNext;
    end
  end

endmodule

// File: rtl/dupDmaReq.sv
module dupDmaReq
  import dupDmaPkg::*;
#(
  parameter int TX_DEPTH = 512,
  parameter int RX_DEPTH = 512,
  parameter int LEN_W    = 11,
  localparam int TX_W = $clog2(TX_DEPTH + 1),
  localparam int RX_W = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fullDuplex,
  input  logic             runtAccept,
  input  logic [1:0]       txWmSel,
  input  logic [1:0]       rxWmSel,
  input  logic [TX_W-1:0]  txLevel,
  input  logic [RX_W-1:0]  rxLevel,
  input  logic             txStart,
  input  logic             txByteSent,
  input  logic             txAbort,
  input  logic             rxEof,
  input  logic             rxFrameOk,
  input  logic [LEN_W-1:0] rxFrameLen,
  input  logic [LEN_W-1:0] rxByteCnt,
  output logic             txDmaReq,
  output logic             rxDmaReq,
  output logic             txRetainHead
);

  ctlStrobe_t ctl;
  logic       headDone;
  logic       rxLevelZero;

  dupDmaCtrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fullDuplex (fullDuplex),
    .runtAccept (runtAccept),
    .txStart    (txStart),
    .txAbort    (txAbort),
    .txByteSent (txByteSent),
    .headDone   (headDone),
    .rxEof      (rxEof),
    .rxFrameOk  (rxFrameOk),
    .rxFrameLen (rxFrameLen),
    .rxByteCnt  (rxByteCnt),
    .rxLevelZero(rxLevelZero),
    .ctl        (ctl),
    .retainHead (txRetainHead)
  );

  dupDmaDatapath #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .txWmSel    (txWmSel),
    .rxWmSel    (rxWmSel),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .headDone   (headDone),
    .rxLevelZero(rxLevelZero),
    .txDmaReq   (txDmaReq),
    .rxDmaReq   (rxDmaReq)
  );

endmodule

// File: rtl/dupDmaReqChk.sv
module dupDmaReqChk
  import dupDmaPkg::*;
#(
  parameter int TX_DEPTH = 512,
  parameter int RX_DEPTH = 512,
  parameter int LEN_W    = 11,
  localparam int TX_W = $clog2(TX_DEPTH + 1),
  localparam int RX_W = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             fullDuplex,
  input logic [1:0]       txWmSel,
  input logic [1:0]       rxWmSel,
  input logic [TX_W-1:0]  txLevel,
  input logic [RX_W-1:0]  rxLevel,
  input logic             txStart,
  input logic             txAbort,
  input logic             txDmaReq,
  input logic             rxDmaReq,
  input logic             txRetainHead
);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!txDmaReq && !rxDmaReq && !txRetainHead));

  // R3
  a_r3_start_retains: assert property (@(posedge clk) disable iff (!rstN)
    (!fullDuplex && txStart && !txAbort) |=> txRetainHead);

  // R5
  a_r5_abort_releases: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |=> !txRetainHead);

  // R6
  a_r6_fd_no_retain: assert property (@(posedge clk) disable iff (!rstN)
    fullDuplex |=> !txRetainHead);

  // R2
  a_r2_fd_tx_watermark: assert property (@(posedge clk) disable iff (!rstN)
    (fullDuplex && !txRetainHead) |=>
      (txDmaReq == ((int'(TX_DEPTH) - int'($past(txLevel))) >=
                    int'(wmBytes($past(txWmSel))))));

  // R7
  a_r7_fd_rx_watermark: assert property (@(posedge clk) disable iff (!rstN)
    (fullDuplex && (int'(rxLevel) >= int'(wmBytes(rxWmSel)))) |=> rxDmaReq);

endmodule

bind dupDmaReq dupDmaReqChk #(
  .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rstN(rstN), .fullDuplex(fullDuplex),
  .txWmSel(txWmSel), .rxWmSel(rxWmSel), .txLevel(txLevel), .rxLevel(rxLevel),
  .txStart(txStart), .txAbort(txAbort),
  .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .txRetainHead(txRetainHead)
);

// File: tb/dupDmaReq_bench.sv
`timescale 1ns/1ps
module dupDmaReq_bench;

  localparam int TX_DEPTH = 512;
  localparam int RX_DEPTH = 512;
  localparam int LEN_W    = 11;
  localparam int TX_W     = $clog2(TX_DEPTH + 1);
  localparam int RX_W     = $clog2(RX_DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fullDuplex = 1'b0, runtAccept = 1'b0;
  logic [1:0] txWmSel = '0, rxWmSel = '0;
  logic [TX_W-1:0] txLevel = '0;
  logic [RX_W-1:0] rxLevel = '0;
  logic txStart = 1'b0, txByteSent = 1'b0, txAbort = 1'b0;
  logic rxEof = 1'b0, rxFrameOk = 1'b0;
  logic [LEN_W-1:0] rxFrameLen = '0, rxByteCnt = '0;
  logic txDmaReq, rxDmaReq, txRetainHead;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dupDmaReq #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .LEN_W(LEN_W)) u_dupDmaReq (
    .clk(clk), .rstN(rstN), .fullDuplex(fullDuplex), .runtAccept(runtAccept),
    .txWmSel(txWmSel), .rxWmSel(rxWmSel), .txLevel(txLevel), .rxLevel(rxLevel),
    .txStart(txStart), .txByteSent(txByteSent), .txAbort(txAbort),
    .rxEof(rxEof), .rxFrameOk(rxFrameOk), .rxFrameLen(rxFrameLen),
    .rxByteCnt(rxByteCnt), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .txRetainHead(txRetainHead)
  );

  function automatic int wm(input int code);
    case (code)
      0: return 16;
      1: return 64;
      2: return 128;
      default: return 256;
    endcase
  endfunction

  // Advance one edge; inputs change and outputs are read 1 ns after it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic sendBytes(input int n);
    for (int i = 0; i < n; i++) begin
      txByteSent = 1'b1;
      txLevel    = txLevel - 1'b1;
      tick();
    end
    txByteSent = 1'b0;
  endtask

  task automatic tReset();
    rstN = 1'b0; txLevel = '0; rxLevel = 9'd300; fullDuplex = 1'b1;
    tick(); tick();
    chk("R1", "txDmaReq in reset", txDmaReq, 1'b0);
    chk("R1", "rxDmaReq in reset", rxDmaReq, 1'b0);
    chk("R1", "txRetainHead in reset", txRetainHead, 1'b0);
    rxLevel = '0; rstN = 1'b1;
    tick();
  endtask

  task automatic tTxWatermark();
    fullDuplex = 1'b1;
    for (int c = 0; c < 4; c++) begin
      txWmSel = 2'(c);
      txLevel = TX_W'(TX_DEPTH - wm(c));
      tick();
      chk("R2", "tx free at watermark", txDmaReq, 1'b1);
      txLevel = TX_W'(TX_DEPTH - wm(c) + 1);
      tick();
      chk("R2", "tx free one short", txDmaReq, 1'b0);
    end
  endtask

  task automatic tTxRetain();
    fullDuplex = 1'b0; txWmSel = 2'd1; txLevel = TX_W'(449);
    tick();
    chk("R2", "hd free 63 below 64", txDmaReq, 1'b0);
    txStart = 1'b1; tick(); txStart = 1'b0;
    chk("R3", "retain after start", txRetainHead, 1'b1);
    sendBytes(10);
    tick();
    chk("R4", "sent head bytes still occupied", txDmaReq, 1'b0);
    sendBytes(53);
    chk("R3", "retain held after 63 bytes", txRetainHead, 1'b1);
    sendBytes(1);
    chk("R3", "retain released at byte 64", txRetainHead, 1'b0);
    tick();
    chk("R4", "free restored after release", txDmaReq, 1'b1);
  endtask

  task automatic tTxAbort();
    fullDuplex = 1'b0; txLevel = TX_W'(449);
    txStart = 1'b1; tick(); txStart = 1'b0;
    sendBytes(5);
    txAbort = 1'b1; tick(); txAbort = 1'b0;
    chk("R5", "abort releases head", txRetainHead, 1'b0);
    txStart = 1'b1; txAbort = 1'b1; tick(); txStart = 1'b0; txAbort = 1'b0;
    chk("R5", "abort beats start", txRetainHead, 1'b0);
  endtask

  task automatic tTxFullDuplex();
    fullDuplex = 1'b0; txLevel = TX_W'(449);
    txStart = 1'b1; tick(); txStart = 1'b0;
    fullDuplex = 1'b1; tick();
    chk("R6", "entering full duplex clears head", txRetainHead, 1'b0);
    txStart = 1'b1; tick(); txStart = 1'b0;
    chk("R6", "start in full duplex", txRetainHead, 1'b0);
    sendBytes(10);
    tick();
    chk("R6", "full duplex ignores sent bytes", txDmaReq, 1'b1);
  endtask

  task automatic tRxWatermark();
    fullDuplex = 1'b1;
    for (int c = 0; c < 4; c++) begin
      rxWmSel = 2'(c);
      rxLevel = RX_W'(wm(c));
      tick();
      chk("R7", "rx level at watermark", rxDmaReq, 1'b1);
      rxLevel = RX_W'(wm(c) - 1);
      tick();
      chk("R10", "rx level below watermark", rxDmaReq, 1'b0);
    end
    rxLevel = '0; tick();
  endtask

  task automatic tRxFrame();
    fullDuplex = 1'b1; rxWmSel = 2'd3; rxLevel = RX_W'(30);
    rxEof = 1'b1; rxFrameOk = 1'b1; rxFrameLen = LEN_W'(30);
    tick(); rxEof = 1'b0;
    chk("R8", "short valid frame requests", rxDmaReq, 1'b1);
    rxLevel = RX_W'(10); tick();
    chk("R8", "pending frame holds request", rxDmaReq, 1'b1);
    rxLevel = '0; tick();
    chk("R10", "drained fifo drops request", rxDmaReq, 1'b0);
    rxLevel = RX_W'(30); rxEof = 1'b1; rxFrameOk = 1'b0;
    tick(); rxEof = 1'b0;
    chk("R11", "invalid frame end", rxDmaReq, 1'b0);
    rxLevel = '0; tick();
  endtask

  task automatic tRxHalf();
    fullDuplex = 1'b0; runtAccept = 1'b0; rxWmSel = 2'd0;
    rxByteCnt = LEN_W'(20); rxLevel = RX_W'(20); tick();
    chk("R9", "gate closed under 64 bytes", rxDmaReq, 1'b0);
    rxByteCnt = LEN_W'(64); rxLevel = RX_W'(64); tick();
    chk("R9", "gate open at 64 bytes", rxDmaReq, 1'b1);
    rxByteCnt = '0; rxLevel = '0; tick();
    rxWmSel = 2'd3; rxLevel = RX_W'(40);
    rxEof = 1'b1; rxFrameOk = 1'b1; rxFrameLen = LEN_W'(40);
    tick(); rxEof = 1'b0;
    chk("R11", "strict mode drops short frame", rxDmaReq, 1'b0);
    rxLevel = RX_W'(80); rxEof = 1'b1; rxFrameLen = LEN_W'(80);
    tick(); rxEof = 1'b0;
    chk("R11", "strict mode long frame", rxDmaReq, 1'b1);
    rxLevel = '0; tick();
  endtask

  task automatic tRunt();
    fullDuplex = 1'b0; runtAccept = 1'b1; rxWmSel = 2'd0;
    rxByteCnt = LEN_W'(20); rxLevel = RX_W'(20); tick();
    chk("R12", "no gate with runt accept", rxDmaReq, 1'b1);
    rxByteCnt = '0; rxLevel = '0; tick();
    rxWmSel = 2'd3; rxLevel = RX_W'(40);
    rxEof = 1'b1; rxFrameOk = 1'b1; rxFrameLen = LEN_W'(40);
    tick(); rxEof = 1'b0;
    chk("R12", "short frame with runt accept", rxDmaReq, 1'b1);
    rxLevel = '0; runtAccept = 1'b0; tick();
  endtask

  initial begin
    tReset();
    tTxWatermark();
    tTxRetain();
    tTxAbort();
    tTxFullDuplex();
    tRxWatermark();
    tRxFrame();
    tRxHalf();
    tRunt();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule